// File: doc/BRIEF.md
# External Bus Interface Sequencer

This block sits between a processor core and a single external 16-bit memory and I/O bus. In one core cycle the core can ask for up to three accesses at once: a data write, a data read and a program fetch. The block takes them all in one start pulse and runs them one at a time on the shared address and data lines. The write goes first, then the read, then the fetch.

For each external access the block drives one active-low space select (program, data or I/O), a read/write line and an active-low strobe. It holds the cycle open until the ready input is sampled high. Data-space accesses that land in a global window at the top of data space also pull an active-low bus-request line, with the same timing as the address. An 8-bit register sets the size of that window as a count of 256-word pages. The core gets back the read word, the fetched word and a one-cycle done pulse once every access it asked for has finished.

Top module: `ebus_seq`

## Requirements
- R1: When several requests are accepted together, the external accesses run strictly in the order write, read, fetch; requests that are absent are skipped with no bus cycle.
- R2: A start pulse is accepted only while `busy` is low; a start while an operation is in progress has no effect on the accesses performed or on the done pulse count.
- R3: During each access exactly one select is low: `ps_n` for a fetch, `is_n` for a read or write whose I/O flag is set, otherwise `ds_n`; the select pattern {ps_n,ds_n,is_n} is 3'b011, 3'b101 or 3'b110.
- R4: `rw` is high for reads and fetches and low for writes; the write word appears on `bus_data` during a write and the block does not drive `bus_data` during reads.
- R5: The first access starts in the cycle after the accepted start; `strb_n` is low for the whole of every access, and an access lasts one cycle plus one cycle for each cycle in which `ready` is sampled low; the next access follows with no gap.
- R6: While `ready` is low, `bus_addr`, the selects and `strb_n` keep their values.
- R7: A read or fetch word is captured on the clock edge where `ready` is high and is then presented on `rd_data` or `fetch_data` respectively.
- R8: A data-space access (not I/O, not fetch) with address bit 15 set is global when 255 minus address bits [15:8] is less than the global page count; `br_n` is then low for the whole access, alongside the address. A count of 0 makes nothing global, and counts above 128 still cover only the upper 32K.
- R9: `done` is high for exactly one cycle, in the cycle after the last access finishes, or in the cycle after a start that carries no request.
- R10: With nothing in progress, and after reset, all selects, `strb_n` and `br_n` are high, `rw` is high, `done` and `busy` are low, and `rd_data` and `fetch_data` are zero.
- R11: `gbl_we` high loads `gbl_din` into the global page count on the next clock edge; the count resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Core start pulse |
| wr_req | input | 1 | Data write requested |
| wr_io | input | 1 | Write targets I/O space |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write word |
| rd_req | input | 1 | Data read requested |
| rd_io | input | 1 | Read targets I/O space |
| rd_addr | input | 16 | Read address |
| fe_req | input | 1 | Program fetch requested |
| fe_addr | input | 16 | Fetch address |
| gbl_we | input | 1 | Load global page count |
| gbl_din | input | 8 | New global page count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read word |
| fetch_data | output | 16 | Last fetched word |
| bus_addr | output | 16 | External address |
| bus_data | inout | 16 | External data |
| ps_n | output | 1 | Program space select, active low |
| ds_n | output | 1 | Data space select, active low |
| is_n | output | 1 | I/O space select, active low |
| rw | output | 1 | High read, low write |
| strb_n | output | 1 | Access strobe, active low |
| br_n | output | 1 | Bus request for global accesses, active low |
| ready | input | 1 | External ready, active high |

## Verification
The hardest situation to reach is the handover between two accesses when the first one has been stretched by wait states: on a single edge the controller drops the old access and launches the next from the latched request copies. A second hard one is a start that arrives in the middle of such a stretched access. The bench models the external device with a responder that holds ready low for a set number of cycles in each access. It can also pulse start, with a new write request, at a chosen cycle inside an operation, and it then checks that no extra access or done pulse appears.

// File: rtl/ebus_pkg.sv
// Shared definitions for the external bus sequencer.
// Request slots are numbered in service order: lower index runs first.
package ebus_pkg;
    localparam int NREQ  = 3;
    localparam int IX_WR = 0;
    localparam int IX_RD = 1;
    localparam int IX_FE = 2;

    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2
    } space_e;
endpackage

// File: rtl/ebus_order.sv
// Fixed-priority picker: grants the lowest-index set bit of the pending mask.
// Assumes index order equals the required service order.
module ebus_order #(
    parameter int N = 3
) (
    input  logic [N-1:0] pend,
    output logic [N-1:0] grant,
    output logic         any
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pick
            if (i == 0) begin : g_first
                // slot 0 always wins when present
                assign grant[i] = pend[i];
            end else begin : g_rest
                // a later slot wins only when every earlier slot is empty
                assign grant[i] = pend[i] & ~(|pend[i-1:0]);
            end
        end
    endgenerate

    assign any = |pend;

    // at most one slot is granted at a time
    always_comb begin
        a_r1_grant_onehot: assert ($onehot0(grant));
    end
endmodule

// File: rtl/ebus_gregion.sv
// Global window register and decode.
// Holds a page count; a data-space page is global when its distance from the
// top page is below the count and it lies in the upper half of data space.
// Assumes the page index is the top PW bits of the address.
module ebus_gregion
    import ebus_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [PW-1:0] cfg_din,
    input  logic [PW-1:0] page,
    input  space_e        space,
    output logic          hit
);
    logic [PW-1:0] cfg_q;
    logic [PW-1:0] from_top;

    // page count register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_din;
    end

    // distance of the page from the top of data space, and window test
    always_comb begin
        from_top = ~page;
        hit      = (space == SP_DATA) && page[PW-1] && (from_top < cfg_q);
    end
endmodule

// File: rtl/ebus_ctl.sv
// Operation controller: accepts a start with up to three requests, keeps the
// pending set, and issues one access descriptor at a time in service order.
// Assumes the core holds request fields valid in the start cycle only; they
// are copied here for the accesses that follow.
module ebus_ctl
    import ebus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_req,
    input  logic          wr_io,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic          rd_io,
    input  logic [AW-1:0] rd_addr,
    input  logic          fe_req,
    input  logic [AW-1:0] fe_addr,
    input  logic          ready,
    output logic          launch,
    output logic [AW-1:0] l_addr,
    output space_e        l_space,
    output logic          l_write,
    output logic [DW-1:0] l_wdata,
    output logic          finish,
    output logic          busy,
    output logic          done
);
    logic            active;
    logic [NREQ-1:0] pend;
    logic [NREQ-1:0] cur;
    logic [NREQ-1:0] src;
    logic [NREQ-1:0] grant;
    logic            any;
    logic            take;

    logic [AW-1:0]   wa_q, ra_q, fa_q;
    logic [DW-1:0]   wd_q;
    logic            wio_q, rio_q;

    // accept / complete events
    always_comb begin
        take   = start & ~active;
        finish = active & ready;
        src    = take ? {fe_req, rd_req, wr_req} : (pend & ~cur);
        launch = (take | finish) & any;
    end

    ebus_order #(.N(NREQ)) u_order (
        .pend  (src),
        .grant (grant),
        .any   (any)
    );

    // descriptor of the access being launched, live fields on the start cycle
    always_comb begin
        l_addr  = '0;
        l_space = SP_DATA;
        l_write = 1'b0;
        l_wdata = take ? wr_data : wd_q;
        if (grant[IX_WR]) begin
            l_addr  = take ? wr_addr : wa_q;
            l_space = (take ? wr_io : wio_q) ? SP_IO : SP_DATA;
            l_write = 1'b1;
        end else if (grant[IX_RD]) begin
            l_addr  = take ? rd_addr : ra_q;
            l_space = (take ? rd_io : rio_q) ? SP_IO : SP_DATA;
        end else if (grant[IX_FE]) begin
            l_addr  = take ? fe_addr : fa_q;
            l_space = SP_PROG;
        end
    end

    // copy request fields when an operation is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa_q <= '0; ra_q <= '0; fa_q <= '0; wd_q <= '0;
            wio_q <= 1'b0; rio_q <= 1'b0;
        end else if (take) begin
            wa_q <= wr_addr; ra_q <= rd_addr; fa_q <= fe_addr; wd_q <= wr_data;
            wio_q <= wr_io; rio_q <= rd_io;
        end
    end

    // pending set, current slot and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pend   <= '0;
            cur    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take || finish) begin
                pend <= src;
                if (any) begin
                    cur    <= grant;
                    active <= 1'b1;
                end else begin
                    cur    <= '0;
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign busy = active;

    // R1: a fetch runs only after the write and read slots are cleared
    a_r1_fetch_last: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cur[IX_FE]) |-> (pend[IX_WR] == 1'b0 && pend[IX_RD] == 1'b0));

    // R1: a read runs only after the write slot is cleared
    a_r1_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cur[IX_RD]) |-> !pend[IX_WR]);

    // R2: a start during an unfinished access leaves the pending set alone
    a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start && !ready) |=> ($stable(pend) && $stable(cur)));

    // R9: done never lasts two cycles
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/ebus_pins.sv
// Pin stage: registers every external control and address output from the
// launched descriptor, returns pins to idle after the last access, and
// captures returned words on the completing edge.
// Assumes launch and finish come from the controller in the same cycle when
// one access hands over to the next.
module ebus_pins
    import ebus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] l_addr,
    input  space_e        l_space,
    input  logic          l_write,
    input  logic [DW-1:0] l_wdata,
    input  logic          l_global,
    input  logic          finish,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] bus_addr,
    output logic          ps_n,
    output logic          ds_n,
    output logic          is_n,
    output logic          rw,
    output logic          strb_n,
    output logic          br_n,
    output logic          drv,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] fe_data
);
    // address, selects, direction, strobe and bus request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
            ps_n <= 1'b1; ds_n <= 1'b1; is_n <= 1'b1;
            rw <= 1'b1; strb_n <= 1'b1; br_n <= 1'b1;
            drv <= 1'b0; wdata <= '0;
        end else if (launch) begin
            bus_addr <= l_addr;
            ps_n     <= (l_space != SP_PROG);
            ds_n     <= (l_space != SP_DATA);
            is_n     <= (l_space != SP_IO);
            rw       <= ~l_write;
            strb_n   <= 1'b0;
            br_n     <= ~l_global;
            drv      <= l_write;
            wdata    <= l_wdata;
        end else if (finish) begin
            ps_n <= 1'b1; ds_n <= 1'b1; is_n <= 1'b1;
            rw <= 1'b1; strb_n <= 1'b1; br_n <= 1'b1;
            drv <= 1'b0;
        end
    end

    // capture returned word on the completing edge of a read or fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            fe_data <= '0;
        end else if (finish && rw) begin
            if (!ps_n) fe_data <= bus_in;
            else       rd_data <= bus_in;
        end
    end

    // R3: one select low while strobing
    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_n |-> ($countones({ps_n, ds_n, is_n}) == 2));

    // R10: idle pins are all released
    a_r10_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        strb_n |-> (ps_n && ds_n && is_n && rw && br_n && !drv));

    // R8: bus request only with a data-space access
    a_r8_br_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        !br_n |-> (!ds_n && !strb_n));

    // R4: the block drives data only in write cycles
    a_r4_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
        drv |-> (!rw && !strb_n));
endmodule

// File: rtl/ebus_seq.sv
// External bus sequencer top: ties the controller, the global window decode
// and the pin stage together and owns the tri-state data pins.
// Assumes a single external bus and a synchronous ready input.
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int GBL_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_req,
    input  logic          wr_io,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic          rd_io,
    input  logic [AW-1:0] rd_addr,
    input  logic          fe_req,
    input  logic [AW-1:0] fe_addr,
    input  logic          gbl_we,
    input  logic [GBL_W-1:0] gbl_din,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] fetch_data,
    output logic [AW-1:0] bus_addr,
    inout  wire  [DW-1:0] bus_data,
    output logic          ps_n,
    output logic          ds_n,
    output logic          is_n,
    output logic          rw,
    output logic          strb_n,
    output logic          br_n,
    input  logic          ready
);
    localparam int PAGE_LSB = AW - GBL_W;

    logic          launch, finish, l_write, l_global, drv;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_wdata, wdata;
    space_e        l_space;

    ebus_ctl #(.AW(AW), .DW(DW)) u_ctl (
        .clk (clk), .rst_n (rst_n), .start (start),
        .wr_req (wr_req), .wr_io (wr_io), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_req (rd_req), .rd_io (rd_io), .rd_addr (rd_addr),
        .fe_req (fe_req), .fe_addr (fe_addr), .ready (ready),
        .launch (launch), .l_addr (l_addr), .l_space (l_space),
        .l_write (l_write), .l_wdata (l_wdata), .finish (finish),
        .busy (busy), .done (done)
    );

    ebus_gregion #(.PW(GBL_W)) u_gbl (
        .clk (clk), .rst_n (rst_n), .cfg_we (gbl_we), .cfg_din (gbl_din),
        .page (l_addr[AW-1:PAGE_LSB]), .space (l_space), .hit (l_global)
    );

    ebus_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk (clk), .rst_n (rst_n), .launch (launch), .l_addr (l_addr),
        .l_space (l_space), .l_write (l_write), .l_wdata (l_wdata),
        .l_global (l_global), .finish (finish), .bus_in (bus_data),
        .bus_addr (bus_addr), .ps_n (ps_n), .ds_n (ds_n), .is_n (is_n),
        .rw (rw), .strb_n (strb_n), .br_n (br_n), .drv (drv),
        .wdata (wdata), .rd_data (rd_data), .fe_data (fetch_data)
    );

    // data pins driven only during a write access
    assign bus_data = drv ? wdata : {DW{1'bz}};

    // R6: a cycle with ready low keeps the access unchanged
    a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_n && !ready) |=> (!strb_n && $stable(bus_addr) && $stable({ps_n, ds_n, is_n})));

    // R9: done only arrives once the bus is released
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (strb_n && !busy));
endmodule

// File: tb/sim_ebus_seq.sv
`timescale 1ns/1ps
// Directed bench: a responder models the external device with configurable
// wait states; each task runs one scenario and checks its own results.
module sim_ebus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_req = 1'b0, wr_io = 1'b0, rd_req = 1'b0, rd_io = 1'b0, fe_req = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0, fe_addr = '0;
    logic        gbl_we = 1'b0;
    logic [7:0]  gbl_din = '0;
    logic        ready = 1'b0;
    logic        busy, done, ps_n, ds_n, is_n, rw, strb_n, br_n;
    logic [15:0] rd_data, fetch_data, bus_addr;
    tri   [15:0] bus_data;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // recorded accesses of the last operation
    logic [15:0] a_addr [4];
    logic [2:0]  a_sel  [4];
    logic        a_rw   [4];
    logic        a_br   [4];
    logic [15:0] a_wd   [4];
    bit          hold_ok;
    int          done_cnt;

    always #10 clk = ~clk;

    // device returns a word derived from the address on reads
    assign bus_data = (!strb_n && rw) ? (bus_addr ^ 16'h5A3C) : 16'hzzzz;

    ebus_seq u0 (
        .clk (clk), .rst_n (rst_n), .start (start),
        .wr_req (wr_req), .wr_io (wr_io), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_req (rd_req), .rd_io (rd_io), .rd_addr (rd_addr),
        .fe_req (fe_req), .fe_addr (fe_addr),
        .gbl_we (gbl_we), .gbl_din (gbl_din),
        .busy (busy), .done (done), .rd_data (rd_data), .fetch_data (fetch_data),
        .bus_addr (bus_addr), .bus_data (bus_data),
        .ps_n (ps_n), .ds_n (ds_n), .is_n (is_n), .rw (rw),
        .strb_n (strb_n), .br_n (br_n), .ready (ready)
    );

    function automatic logic [15:0] mem(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_req(input bit w, input bit wio, input logic [15:0] wa, input logic [15:0] wd,
                           input bit r, input bit rio, input logic [15:0] ra,
                           input bit f, input logic [15:0] fa);
        wr_req = w; wr_io = wio; wr_addr = wa; wr_data = wd;
        rd_req = r; rd_io = rio; rd_addr = ra;
        fe_req = f; fe_addr = fa;
    endtask

    task automatic set_gbl(input logic [7:0] v);
        @(negedge clk); gbl_we = 1'b1; gbl_din = v;
        @(negedge clk); gbl_we = 1'b0;
    endtask

    // run one operation; poke>=0 pulses start with a write request at that strobe cycle
    task automatic run_op(input int waits, input int poke, output int nacc, output int cycles);
        int  wc;
        bit  in_acc;
        bit  seen;
        nacc = 0; cycles = 0; wc = 0; in_acc = 1'b0; seen = 1'b0;
        hold_ok = 1'b1; done_cnt = 0;
        @(negedge clk); start = 1'b1; ready = 1'b0;
        @(negedge clk); start = 1'b0;
        for (int it = 0; it < 200; it++) begin
            start = 1'b0;
            if (done) begin seen = 1'b1; done_cnt++; break; end
            if (!strb_n) begin
                if (!in_acc) begin
                    if (nacc < 4) begin
                        a_addr[nacc] = bus_addr; a_sel[nacc] = {ps_n, ds_n, is_n};
                        a_rw[nacc] = rw; a_br[nacc] = br_n; a_wd[nacc] = bus_data;
                    end
                    nacc++; in_acc = 1'b1; wc = 0;
                end else if (nacc <= 4) begin
                    if (bus_addr !== a_addr[nacc-1] || {ps_n, ds_n, is_n} !== a_sel[nacc-1])
                        hold_ok = 1'b0;
                end
                ready = (wc == waits);
                wc++;
                if (ready) in_acc = 1'b0;
                if (cycles == poke) begin start = 1'b1; wr_req = 1'b1; end
                cycles++;
            end else begin
                ready = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; ready = 1'b0;
        check(seen, "R9 done seen", {31'b0, seen}, 32'd1);
        @(negedge clk);
        if (done) done_cnt++;
        check(!done, "R9 done one cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic t_reset;
        check(strb_n && ps_n && ds_n && is_n && br_n, "R10 idle pins after reset",
              {27'b0, strb_n, ps_n, ds_n, is_n, br_n}, 32'h1F);
        check(rw == 1'b1 && !busy && !done, "R10 rw/busy/done after reset",
              {29'b0, rw, busy, done}, 32'h4);
        check(rd_data == 16'h0 && fetch_data == 16'h0, "R10 data regs after reset",
              {rd_data, fetch_data}, 32'h0);
        check(br_n, "R11 page count resets to zero (no global at 0xFFFF)", {31'b0, br_n}, 32'd1);
    endtask

    task automatic t_all_three(input int waits, input bit wio);
        int n, c;
        set_req(1, wio, 16'h1234, 16'hBEEF, 1, 0, 16'h2345, 1, 16'h3456);
        run_op(waits, -1, n, c);
        check(n == 3, "R1 three accesses", n, 3);
        check(a_addr[0] == 16'h1234 && a_addr[1] == 16'h2345 && a_addr[2] == 16'h3456,
              "R1 order write read fetch", {a_addr[0], a_addr[2]}, {16'h1234, 16'h3456});
        check(a_sel[0] == (wio ? 3'b110 : 3'b101), "R3 write select",
              a_sel[0], wio ? 3'b110 : 3'b101);
        check(a_sel[1] == 3'b101 && a_sel[2] == 3'b011, "R3 read and fetch selects",
              {a_sel[1], a_sel[2]}, {3'b101, 3'b011});
        check(!a_rw[0] && a_rw[1] && a_rw[2], "R4 rw per access",
              {a_rw[0], a_rw[1], a_rw[2]}, 3'b011);
        check(a_wd[0] == 16'hBEEF, "R4 write word on bus", a_wd[0], 16'hBEEF);
        check(c == 3 * (waits + 1), "R5 strobe cycles", c, 3 * (waits + 1));
        check(hold_ok, "R6 address and selects held in wait", {31'b0, hold_ok}, 1);
        check(rd_data == mem(16'h2345), "R7 read word", rd_data, mem(16'h2345));
        check(fetch_data == mem(16'h3456), "R7 fetch word", fetch_data, mem(16'h3456));
        check(a_br[0] && a_br[1] && a_br[2], "R8 no request with count zero",
              {a_br[0], a_br[1], a_br[2]}, 3'b111);
    endtask

    task automatic t_subsets;
        int n, c;
        set_req(0, 0, 16'h0, 16'h0, 0, 0, 16'h0, 1, 16'hABCD);
        run_op(1, -1, n, c);
        check(n == 1 && a_sel[0] == 3'b011, "R1 fetch only", {n[15:0], 13'b0, a_sel[0]}, {16'd1, 16'd3});
        check(fetch_data == mem(16'hABCD), "R7 fetch only word", fetch_data, mem(16'hABCD));
        set_req(0, 0, 16'h0, 16'h0, 1, 1, 16'h0042, 1, 16'h0100);
        run_op(0, -1, n, c);
        check(n == 2 && a_addr[0] == 16'h0042 && a_addr[1] == 16'h0100, "R1 read then fetch",
              {a_addr[0], a_addr[1]}, {16'h0042, 16'h0100});
        check(a_sel[0] == 3'b110 && a_rw[0], "R3 I/O read select", {28'b0, a_sel[0], a_rw[0]}, 32'hD);
        check(rd_data == mem(16'h0042), "R7 I/O read word", rd_data, mem(16'h0042));
        check(strb_n && rw && ps_n && ds_n && is_n, "R10 idle after operation",
              {27'b0, strb_n, rw, ps_n, ds_n, is_n}, 32'h1F);
    endtask

    task automatic t_empty;
        int n, c;
        set_req(0, 0, 16'h0, 16'h0, 0, 0, 16'h0, 0, 16'h0);
        run_op(0, -1, n, c);
        check(n == 0 && c == 0, "R9 empty start gives no access", {n[15:0], c[15:0]}, 32'h0);
    endtask

    task automatic t_busy_start;
        int n, c;
        set_req(0, 0, 16'h0, 16'h0, 1, 0, 16'h0777, 0, 16'h0);
        run_op(3, 1, n, c);
        wr_req = 1'b0;
        check(n == 1 && a_addr[0] == 16'h0777, "R2 start while busy ignored",
              {n[15:0], a_addr[0]}, {16'd1, 16'h0777});
        check(c == 4, "R2 access length unchanged", c, 4);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (done || !strb_n) done_cnt += 10;
        end
        check(done_cnt == 1, "R2 single done pulse", done_cnt, 1);
    endtask

    task automatic one_read(input logic [15:0] a, input bit io, input bit exp_gbl, input string tag);
        int n, c;
        set_req(0, 0, 16'h0, 16'h0, 1, io, a, 0, 16'h0);
        run_op(1, -1, n, c);
        check(a_br[0] == !exp_gbl, tag, {31'b0, a_br[0]}, {31'b0, !exp_gbl});
    endtask

    task automatic t_global;
        int n, c;
        set_gbl(8'd2);
        one_read(16'hFF10, 0, 1, "R8 top page global");
        one_read(16'hFE00, 0, 1, "R8 second page global");
        one_read(16'hFD00, 0, 0, "R8 third page outside count 2");
        one_read(16'hFF00, 1, 0, "R8 I/O never global");
        set_req(1, 0, 16'hFFF0, 16'h5555, 0, 0, 16'h0, 1, 16'hFFFF);
        run_op(0, -1, n, c);
        check(!a_br[0] && a_br[1], "R8 global write, fetch not global",
              {30'b0, a_br[0], a_br[1]}, 32'h1);
        set_gbl(8'd255);
        one_read(16'h8000, 0, 1, "R11 count 255 loaded, 0x8000 global");
        one_read(16'h7FFF, 0, 0, "R8 lower half never global");
        set_gbl(8'd0);
        one_read(16'hFFFF, 0, 0, "R8 count zero disables window");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_all_three(0, 0);
        t_all_three(2, 1);
        t_subsets;
        t_empty;
        t_busy_start;
        t_global;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        #2000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule